// File: doc/BRIEF.md
# DMA Channel Control/Status Register Unit

This block is the register front end of one channel of a descriptor-driven DMA controller. A host reads and writes 32-bit words on a simple request bus. The block keeps the channel's descriptor pointers, configuration word, command word and stream-command word. It also holds the interrupt cause, mask and acknowledge logic, which drives one level-sensitive interrupt line. It tracks the channel state (reset, stopped or running) and an end-of-list flag.

The block does not fetch descriptors and does not move data. A separate descriptor engine does that work. This block sends the engine single-cycle strobes: load data descriptor, burst start, load context and continue. The engine sends back cause pulses and an end-of-list pulse, and it supplies the stream-command source field.

Upstream logic selects the channel from the bus address. Each channel has a 0x2000-byte region, so the channel index is the address shifted right by 13. This block receives only the low 8 address bits, which pick the register inside the 0x100-byte window.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the channel state reads as reset (code 1) and `irq` is low. The configuration (0x84), command (0x80), mask (0x8C) and stream-command (0x9C) registers all read as zero.
- R2: Registers are read back with `rd_valid` high and `rd_data` valid one cycle after the request. Five pointer registers (data 0x00, saved-data 0x58, saved-buffer 0x5C, group 0x60, group-down 0x7C) return the last word written to them. `desc_ptr` shows the register at 0x58 and `ctx_ptr` shows the register at 0x7C.
- R3: The state codes are reset = 1, stopped = 2 and running = 4. A configuration write with bit 1 set moves the state to stopped. A configuration write with bit 0 clear moves the state to reset, and this case wins over bit 1. A write of 1 leaves the state unchanged.
- R4: A read of the status register (0x88) is built from live state. The state code is in bits [2:0], the end-of-list flag in bit 5 and `stream_src` in bits [15:8]. All other bits are zero.
- R5: Each set bit of `cause_set` sets the matching raw cause bit, which is read at 0x94. The masked cause, read at 0x98, is raw AND mask. `irq` is the OR of the masked bits. A mask write changes `irq` on the clock edge that stores it.
- R6: A write to the acknowledge register (0x90) clears every raw bit that is set in the written value. The acknowledge register always reads as zero. If a cause pulse and an acknowledge hit the same bit in the same cycle, the bit stays set.
- R7: A stream-command write stores only bits [9:0]. If any bit above bit 9 is set, `err` pulses. If the value has any bit of mask 0x140 set, `ld_desc_stb` pulses. If bit 5 (0x20) is also set, `burst_stb` pulses, the state becomes running and the end-of-list flag clears. Bit 5 on its own does nothing.
- R8: A stream-command write with bit 9 (0x200) set pulses `ld_ctx_stb`.
- R9: Every command-register write pulses `cont_stb` and stores the value. If any bit other than bit 0 is set, `err` also pulses.
- R10: A request that is not a whole aligned word is ignored. Such a request has `req_size` other than 2, or `req_addr[1:0]` not zero. It pulses `err` and returns zero if it is a read. Writes to unlisted or read-only offsets are dropped, and reads of unlisted offsets return zero.
- R11: An `eol_set` pulse sets the end-of-list flag. A burst start clears the flag, unless `eol_set` arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| req_addr | input | 8 | Byte offset inside the channel window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| err | output | 1 | Bad-access or invalid-command pulse |
| cause_set | input | IRQ_W | Interrupt cause set pulses from the engine |
| eol_set | input | 1 | End-of-list pulse from the engine |
| stream_src | input | SRC_W | Stream-command source, reported in status |
| irq | output | 1 | Level interrupt |
| chan_state | output | 3 | One-hot channel state |
| desc_ptr | output | 32 | Saved-data descriptor pointer |
| ctx_ptr | output | 32 | Group-down context pointer |
| ld_desc_stb | output | 1 | Load data descriptor strobe |
| burst_stb | output | 1 | Burst start strobe |
| ld_ctx_stb | output | 1 | Load context strobe |
| cont_stb | output | 1 | Continue strobe |

## Verification
The hardest case to reach from the ports is a cause pulse and an acknowledge that hit the same raw bit in the same clock edge. Only that timing shows whether a set or a clear wins. The bench makes this happen by raising `cause_set` first, then issuing the acknowledge write, so that both are sampled on the same edge. It then reads the raw register. The configuration priority case is reached with the value 2 (stop set, enable clear) after the channel has been moved to stopped, so that the reset rule is seen to override.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  // One-hot channel state codes
  typedef enum logic [2:0] {
    CH_RESET   = 3'b001,
    CH_STOPPED = 3'b010,
    CH_RUNNING = 3'b100
  } ch_state_e;

  localparam int NPTR = 5;

  // Pointer register offsets; index 1 is saved-data, index 4 is group-down
  localparam logic [NPTR-1:0][7:0] PTR_OFS = {8'h7C, 8'h60, 8'h5C, 8'h58, 8'h00};
  localparam int PTR_DESC_IDX = 1;
  localparam int PTR_CTX_IDX  = 4;

  localparam logic [7:0] OFS_CMD  = 8'h80;
  localparam logic [7:0] OFS_CFG  = 8'h84;
  localparam logic [7:0] OFS_STAT = 8'h88;
  localparam logic [7:0] OFS_MASK = 8'h8C;
  localparam logic [7:0] OFS_ACK  = 8'h90;
  localparam logic [7:0] OFS_RAW  = 8'h94;
  localparam logic [7:0] OFS_MSK  = 8'h98;
  localparam logic [7:0] OFS_SCMD = 8'h9C;

  // Stream-command decode masks
  localparam logic [9:0] SC_LOAD_DESC = 10'h140;
  localparam int         SC_BURST_BIT = 5;
  localparam int         SC_LOAD_CTX_BIT = 9;

endpackage

// File: rtl/dma_chan_irq.sv
module dma_chan_irq #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic             ack_we,
  input  logic [IRQ_W-1:0] wr_val,
  input  logic [IRQ_W-1:0] cause_set,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] masked_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_q, raw_d, mask_q, mask_d, ack_clr;

  always_comb begin
    ack_clr = ack_we ? wr_val : '0;
    // Set pulses win over a same-cycle acknowledge
    raw_d   = (raw_q & ~ack_clr) | cause_set;
    mask_d  = mask_we ? wr_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |(raw_q & mask_q);
endmodule

// File: rtl/dma_chan_state.sv
module dma_chan_state
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_bits,
  input  logic       start,
  input  logic       eol_set,
  output ch_state_e  state_o,
  output logic       eol_o
);
  ch_state_e st_q, st_d;
  logic      eol_q, eol_d;

  always_comb begin
    st_d = st_q;
    if (cfg_we) begin
      if (cfg_bits[1])  st_d = CH_STOPPED;
      if (!cfg_bits[0]) st_d = CH_RESET;   // evaluated last: wins
    end
    if (start) st_d = CH_RUNNING;
    eol_d = eol_q;
    if (start)   eol_d = 1'b0;
    if (eol_set) eol_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_RESET;
      eol_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      eol_q <= eol_d;
    end
  end

  assign state_o = st_q;
  assign eol_o   = eol_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int IRQ_W  = 8,
  parameter int SRC_W  = 8,
  parameter int SCMD_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [7:0]       req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic             err,
  input  logic [IRQ_W-1:0] cause_set,
  input  logic             eol_set,
  input  logic [SRC_W-1:0] stream_src,
  output logic             irq,
  output logic [2:0]       chan_state,
  output logic [31:0]      desc_ptr,
  output logic [31:0]      ctx_ptr,
  output logic             ld_desc_stb,
  output logic             burst_stb,
  output logic             ld_ctx_stb,
  output logic             cont_stb
);
  localparam int DW       = 32;
  localparam int WORD_SZ  = 2;
  localparam int SRC_LSB  = 8;
  localparam int EOL_BIT  = 5;

  logic              word_ok, wr_ok, rd_ok;
  logic              cfg_we, cmd_we, mask_we, ack_we, scmd_we;
  logic [DW-1:0]     cfg_q, cfg_d, cmd_q, cmd_d;
  logic [SCMD_W-1:0] scmd_q, scmd_d;
  logic [DW-1:0]     ptr_q [NPTR];
  logic [DW-1:0]     rd_mux, rd_data_q;
  logic              rd_valid_q, err_q, err_d;
  logic              ldd_d, bst_d, ldc_d, cont_d;
  logic              ldd_q, bst_q, ldc_q, cont_q;
  logic [IRQ_W-1:0]  raw, mask, masked;
  ch_state_e         state;
  logic              eol;

  // Access decode
  assign word_ok = (req_size == 2'(WORD_SZ)) && (req_addr[1:0] == 2'b00);
  assign wr_ok   = req_valid && req_write && word_ok;
  assign rd_ok   = req_valid && !req_write && word_ok;
  assign cfg_we  = wr_ok && (req_addr == OFS_CFG);
  assign cmd_we  = wr_ok && (req_addr == OFS_CMD);
  assign mask_we = wr_ok && (req_addr == OFS_MASK);
  assign ack_we  = wr_ok && (req_addr == OFS_ACK);
  assign scmd_we = wr_ok && (req_addr == OFS_SCMD);

  // Pointer registers
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic          we;
    logic [DW-1:0] nxt;
    assign we  = wr_ok && (req_addr == PTR_OFS[g]);
    assign nxt = we ? req_wdata : ptr_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[g] <= '0;
      else        ptr_q[g] <= nxt;
    end
  end

  // Next-state for control registers, strobes and error
  always_comb begin
    cfg_d  = cfg_we  ? req_wdata : cfg_q;
    cmd_d  = cmd_we  ? req_wdata : cmd_q;
    scmd_d = scmd_we ? req_wdata[SCMD_W-1:0] : scmd_q;
    ldd_d  = scmd_we && |(req_wdata[SCMD_W-1:0] & SC_LOAD_DESC);
    bst_d  = ldd_d && req_wdata[SC_BURST_BIT];
    ldc_d  = scmd_we && req_wdata[SC_LOAD_CTX_BIT];
    cont_d = cmd_we;
    err_d  = (req_valid && !word_ok)
          || (cmd_we  && |req_wdata[DW-1:1])
          || (scmd_we && |req_wdata[DW-1:SCMD_W]);
  end

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    unique case (req_addr)
      OFS_CMD:  rd_mux = cmd_q;
      OFS_CFG:  rd_mux = cfg_q;
      OFS_STAT: begin
        rd_mux[2:0]                  = state;
        rd_mux[EOL_BIT]              = eol;
        rd_mux[SRC_LSB +: SRC_W]     = stream_src;
      end
      OFS_MASK: rd_mux[IRQ_W-1:0]  = mask;
      OFS_RAW:  rd_mux[IRQ_W-1:0]  = raw;
      OFS_MSK:  rd_mux[IRQ_W-1:0]  = masked;
      OFS_SCMD: rd_mux[SCMD_W-1:0] = scmd_q;
      default:  rd_mux = '0;
    endcase
    for (int i = 0; i < NPTR; i++)
      if (req_addr == PTR_OFS[i]) rd_mux = ptr_q[i];
    if (!rd_ok) rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      cmd_q      <= '0;
      scmd_q     <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
      ldd_q      <= 1'b0;
      bst_q      <= 1'b0;
      ldc_q      <= 1'b0;
      cont_q     <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      cmd_q      <= cmd_d;
      scmd_q     <= scmd_d;
      rd_data_q  <= rd_mux;
      rd_valid_q <= req_valid && !req_write;
      err_q      <= err_d;
      ldd_q      <= ldd_d;
      bst_q      <= bst_d;
      ldc_q      <= ldc_d;
      cont_q     <= cont_d;
    end
  end

  dma_chan_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (mask_we),
    .ack_we    (ack_we),
    .wr_val    (req_wdata[IRQ_W-1:0]),
    .cause_set (cause_set),
    .raw_o     (raw),
    .mask_o    (mask),
    .masked_o  (masked),
    .irq_o     (irq)
  );

  dma_chan_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_bits (req_wdata[1:0]),
    .start    (bst_d),
    .eol_set  (eol_set),
    .state_o  (state),
    .eol_o    (eol)
  );

  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign err         = err_q;
  assign chan_state  = state;
  assign desc_ptr    = ptr_q[PTR_DESC_IDX];
  assign ctx_ptr     = ptr_q[PTR_CTX_IDX];
  assign ld_desc_stb = ldd_q;
  assign burst_stb   = bst_q;
  assign ld_ctx_stb  = ldc_q;
  assign cont_stb    = cont_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [7:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        err,
  input logic        irq,
  input logic [2:0]  chan_state,
  input logic        ld_desc_stb,
  input logic        burst_stb,
  input logic        ld_ctx_stb,
  input logic        cont_stb
);
  logic word_ok;
  assign word_ok = (req_size == 2'd2) && (req_addr[1:0] == 2'b00);

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_state) == 1);

  // R3
  cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && word_ok && req_addr == 8'h84 && !req_wdata[0]
    |=> chan_state == 3'b001);

  // R5
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && word_ok && req_addr == 8'h8C && req_wdata[7:0] == 8'h00
    |=> !irq);

  // R6
  ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && word_ok && req_addr == 8'h90
    |=> rd_valid && rd_data == 32'h0);

  // R8
  ctx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && word_ok && req_addr == 8'h9C && req_wdata[9]
    |=> ld_ctx_stb);

  // R9
  cont_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && word_ok && req_addr == 8'h80
    |=> cont_stb);

  // R10
  bad_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !word_ok
    |=> err && !ld_desc_stb && !burst_stb && !ld_ctx_stb && !cont_stb);
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_size    (req_size),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data),
  .err         (err),
  .irq         (irq),
  .chan_state  (chan_state),
  .ld_desc_stb (ld_desc_stb),
  .burst_stb   (burst_stb),
  .ld_ctx_stb  (ld_ctx_stb),
  .cont_stb    (cont_stb)
);

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SRC = 8'hA5;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rd_valid, err, irq, eol_set;
  logic [31:0] rd_data, desc_ptr, ctx_ptr;
  logic [7:0]  cause_set, stream_src;
  logic [2:0]  chan_state;
  logic        ld_desc_stb, burst_stb, ld_ctx_stb, cont_stb;

  int checks = 0, fails = 0;
  bit done = 0;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .err(err), .cause_set(cause_set),
    .eol_set(eol_set), .stream_src(stream_src), .irq(irq), .chan_state(chan_state),
    .desc_ptr(desc_ptr), .ctx_ptr(ctx_ptr), .ld_desc_stb(ld_desc_stb),
    .burst_stb(burst_stb), .ld_ctx_stb(ld_ctx_stb), .cont_stb(cont_stb)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [7:0] a, input logic [31:0] d,
                     input logic [1:0] sz);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_size = sz;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, d, 2'd2);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    acc(1'b0, a, 32'h0, 2'd2);
    d = rd_valid ? rd_data : 32'hDEAD_BEEF;
  endtask

  task automatic strobes(input string req, input logic [3:0] exp);
    chk(req, {28'h0, ld_desc_stb, burst_stb, ld_ctx_stb, cont_stb}, {28'h0, exp});
  endtask

  task automatic pulse_cause(input logic [7:0] c);
    @(negedge clk); cause_set = c;
    @(posedge clk); #1; cause_set = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 state", {29'h0, chan_state}, 32'h1);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(8'h84, v); chk("R1 cfg", v, 0);
    rd(8'h80, v); chk("R1 cmd", v, 0);
    rd(8'h8C, v); chk("R1 mask", v, 0);
    rd(8'h9C, v); chk("R1 scmd", v, 0);
    rd(8'h88, v); chk("R4 status reset", v, {16'h0, SRC, 8'h01});
  endtask

  task automatic t_ptrs;
    logic [31:0] v;
    logic [7:0] ofs [5] = '{8'h00, 8'h58, 8'h5C, 8'h60, 8'h7C};
    for (int i = 0; i < 5; i++) wr(ofs[i], 32'h1000_0000 + 32'(i) * 32'h111);
    for (int i = 0; i < 5; i++) begin
      rd(ofs[i], v);
      chk("R2 ptr readback", v, 32'h1000_0000 + 32'(i) * 32'h111);
    end
    chk("R2 desc_ptr", desc_ptr, 32'h1000_0111);
    chk("R2 ctx_ptr", ctx_ptr, 32'h1000_0444);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(8'h84, 32'h3); chk("R3 stop", {29'h0, chan_state}, 32'h2);
    wr(8'h84, 32'h1); chk("R3 hold", {29'h0, chan_state}, 32'h2);
    rd(8'h84, v);     chk("R3 cfg readback", v, 32'h1);
    wr(8'h84, 32'h2); chk("R3 reset priority", {29'h0, chan_state}, 32'h1);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(8'h8C, 32'h04);
    pulse_cause(8'h05);
    rd(8'h94, v); chk("R5 raw", v, 32'h05);
    rd(8'h98, v); chk("R5 masked", v, 32'h04);
    chk("R5 irq high", {31'h0, irq}, 1);
    wr(8'h8C, 32'h00); chk("R5 irq after mask clear", {31'h0, irq}, 0);
    wr(8'h8C, 32'h01); chk("R5 irq after mask set", {31'h0, irq}, 1);
  endtask

  task automatic t_ack;
    logic [31:0] v;
    wr(8'h90, 32'h01);
    chk("R6 irq after ack", {31'h0, irq}, 0);
    rd(8'h94, v); chk("R6 raw after ack", v, 32'h04);
    rd(8'h90, v); chk("R6 ack reads zero", v, 0);
    cause_set = 8'h04;
    wr(8'h90, 32'h04);
    cause_set = 0;
    rd(8'h94, v); chk("R6 set wins over ack", v, 32'h04);
    wr(8'h90, 32'hFF);
    rd(8'h94, v); chk("R6 ack all", v, 0);
  endtask

  task automatic t_scmd;
    logic [31:0] v;
    wr(8'h9C, 32'h140); strobes("R7 load only", 4'b1000);
    chk("R7 no start", {29'h0, chan_state}, 32'h1);
    wr(8'h9C, 32'h020); strobes("R7 burst alone", 4'b0000);
    chk("R7 burst alone state", {29'h0, chan_state}, 32'h1);
    wr(8'h9C, 32'h060); strobes("R7 load+burst", 4'b1100);
    chk("R7 running", {29'h0, chan_state}, 32'h4);
    wr(8'h9C, 32'h200); strobes("R8 ctx load", 4'b0010);
    wr(8'h9C, 32'h7FF);
    chk("R7 high bits err", {31'h0, err}, 1);
    strobes("R8 all strobes", 4'b1110);
    rd(8'h9C, v); chk("R7 low bits stored", v, 32'h3FF);
  endtask

  task automatic t_eol;
    logic [31:0] v;
    @(negedge clk); eol_set = 1;
    @(posedge clk); #1; eol_set = 0;
    rd(8'h88, v); chk("R11 eol set", v, {16'h0, SRC, 8'h24});
    wr(8'h9C, 32'h120);
    rd(8'h88, v); chk("R11 eol cleared by burst", v, {16'h0, SRC, 8'h04});
  endtask

  task automatic t_cmd;
    logic [31:0] v;
    wr(8'h80, 32'h1); strobes("R9 continue", 4'b0001);
    chk("R9 valid no err", {31'h0, err}, 0);
    wr(8'h80, 32'h2); strobes("R9 continue invalid", 4'b0001);
    chk("R9 invalid err", {31'h0, err}, 1);
    rd(8'h80, v); chk("R9 cmd stored", v, 32'h2);
  endtask

  task automatic t_bad;
    logic [31:0] v;
    acc(1'b1, 8'h84, 32'h0, 2'd0);
    chk("R10 byte write err", {31'h0, err}, 1);
    strobes("R10 no strobes", 4'b0000);
    chk("R10 state untouched", {29'h0, chan_state}, 32'h4);
    acc(1'b1, 8'h86, 32'h0, 2'd2);
    chk("R10 misaligned err", {31'h0, err}, 1);
    rd(8'h84, v); chk("R10 cfg untouched", v, 32'h2);
    acc(1'b0, 8'h84, 32'h0, 2'd1);
    chk("R10 half read zero", rd_data, 0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R10 unlisted read", v, 0);
    wr(8'h94, 32'hFF);
    rd(8'h94, v); chk("R10 raw read-only", v, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_size = 2'd2; req_addr = 0;
    req_wdata = 0; cause_set = 0; eol_set = 0; stream_src = SRC;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_ptrs();
    t_cfg();
    t_irq();
    t_ack();
    t_scmd();
    t_eol();
    t_cmd();
    t_bad();
    finish_run();
  end
endmodule